// File: doc/BRIEF.md
# Configurable Pixel Component Extractor

This block turns a packed framebuffer pixel word of up to four bytes into three 8-bit colour components (red, green, blue) for a display output path. Software describes the pixel layout through a small register set: one format register gives the number of bytes that make up a pixel, and one selector register per colour gives the bit window to pull from the word and a fallback value.

Each colour channel shifts the (byte-masked) word down by its lowest-bit index and takes the number of bits its count field asks for. The result is scaled to 8 bits. A narrower field is placed at the top of the output and its upper bits are repeated into the low bits. A wider field keeps only its top 8 bits. The fallback value takes the place of the extracted one when the channel's count is zero, when the pixel is outside the visible area, or when the upstream buffer has run dry. Results leave through a single register stage.

Top module: `pix_unpack`

## Requirements
- R1: After reset, `out_valid` is 0, all three components are 0, and every configuration field is 0. A visible pixel sent before any register write therefore yields 0 on all components.
- R2: `out_valid` equals the `pix_valid` value of the previous clock cycle.
- R3: A selector register keeps the lowest-bit index in bits [4:0] and the bit count in bits [11:8]. A count of exactly 8 outputs word bits [index+7:index].
- R4: A count n from 1 to 7 places the n-bit field in output bits [7:8-n]. The remaining low bits repeat the field from its most significant bit downwards, cyclically. For example, 5-bit 10110 gives 8'hB5, and 3-bit 101 gives 8'hB6.
- R5: A count from 9 to 15 outputs the top 8 bits of the extracted field.
- R6: The format register (address 0) holds bytes-per-pixel minus one in bits [4:3]. Word bytes above that count read as zero before extraction.
- R7: A selector register keeps the fallback value in bits [23:16]. A count of zero outputs that fallback value.
- R8: When `in_visible` is 0 or `underrun` is 1 on a valid pixel, every channel outputs its fallback value.
- R9: While `pix_valid` is 0, the three components hold their previous values.
- R10: Register addresses are 0 for format, 1 for red, 2 for green and 3 for blue. A write changes only the addressed register. It applies to pixels presented from the cycle after the write, so a pixel in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_word | input | 32 | Packed pixel word |
| pix_valid | input | 1 | Pixel word is valid this cycle |
| in_visible | input | 1 | Pixel lies inside the visible area |
| underrun | input | 1 | Upstream buffer has no data |
| comp_r | output | 8 | Red component |
| comp_g | output | 8 | Green component |
| comp_b | output | 8 | Blue component |
| out_valid | output | 1 | Components are valid |

## Verification
The bench builds the block with its default parameters: a four-byte pixel word and a 2-bit address. With these settings every lowest-bit index from 0 to 31 and all four byte-count settings can be reached. This lets the table cover fields that touch the top bit of the word, fields cut off by the byte mask, and every scaling path: count 1 to 7, exactly 8, and wider than 8. Directed cases then cover the fallback paths for blanking and underrun, holding while the input is idle, isolation between channel registers, and a write that arrives in the same cycle as a pixel.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
    localparam int COMP_W   = 8;
    localparam int LEN_W    = 4;
    localparam int IDX_W    = 5;
    localparam int NUM_CH   = 3;
    localparam int DFLT_LSB = 16;
    localparam int LEN_LSB  = 8;
    localparam int IDX_LSB  = 0;
    localparam int BPP_LSB  = 3;
    localparam int ADDR_FMT = 0;

    typedef struct packed {
        logic [COMP_W-1:0] dflt;
        logic [LEN_W-1:0]  len;
        logic [IDX_W-1:0]  idx;
    } chan_sel_t;
endpackage

// File: rtl/pix_cfg_regs.sv
module pix_cfg_regs
    import pix_unpack_pkg::*;
#(
    parameter int PIX_BYTES = 4,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    localparam int BPP_W    = $clog2(PIX_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [BPP_W-1:0]             bytes_m1,
    output chan_sel_t [NUM_CH-1:0]       sel_cfg
);
    typedef struct packed {
        logic [BPP_W-1:0]        bytes_m1;
        chan_sel_t [NUM_CH-1:0]  sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == ADDR_W'(ADDR_FMT)) begin
                cfg_d.bytes_m1 = wdata[BPP_LSB +: BPP_W];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr == ADDR_W'(c + 1)) begin
                    cfg_d.sel[c].dflt = wdata[DFLT_LSB +: COMP_W];
                    cfg_d.sel[c].len  = wdata[LEN_LSB +: LEN_W];
                    cfg_d.sel[c].idx  = wdata[IDX_LSB +: IDX_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign bytes_m1 = cfg_q.bytes_m1;
    assign sel_cfg  = cfg_q.sel;
endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
    import pix_unpack_pkg::*;
#(
    parameter int PIX_BYTES = 4,
    localparam int PIX_W    = 8 * PIX_BYTES,
    localparam int BPP_W    = $clog2(PIX_BYTES)
) (
    input  logic [PIX_W-1:0]  pix_word,
    input  logic [BPP_W-1:0]  bytes_m1,
    input  chan_sel_t         sel,
    input  logic              force_dflt,
    output logic [COMP_W-1:0] comp_out
);
    logic [PIX_W-1:0]  masked;
    logic [PIX_W-1:0]  shifted;
    logic [COMP_W-1:0] scaled;
    logic [LEN_W-1:0]  pos;

    always_comb begin
        masked = '0;
        for (int b = 0; b < PIX_BYTES; b++) begin
            if (BPP_W'(b) <= bytes_m1) begin
                masked[b*8 +: 8] = pix_word[b*8 +: 8];
            end
        end
        shifted = masked >> sel.idx;

        // walk the field from its top bit, wrapping to repeat it below
        pos    = sel.len - 1'b1;
        scaled = '0;
        for (int k = 0; k < COMP_W; k++) begin
            scaled[COMP_W-1-k] = shifted[pos];
            if (pos == '0) begin
                pos = sel.len - 1'b1;
            end else begin
                pos = pos - 1'b1;
            end
        end

        comp_out = (force_dflt || sel.len == '0) ? sel.dflt : scaled;
    end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int PIX_BYTES = 4,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    localparam int PIX_W    = 8 * PIX_BYTES,
    localparam int BPP_W    = $clog2(PIX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [PIX_W-1:0]  pix_word,
    input  logic              pix_valid,
    input  logic              in_visible,
    input  logic              underrun,
    output logic [COMP_W-1:0] comp_r,
    output logic [COMP_W-1:0] comp_g,
    output logic [COMP_W-1:0] comp_b,
    output logic              out_valid
);
    typedef struct packed {
        logic                           valid;
        logic [NUM_CH-1:0][COMP_W-1:0]  comp;
    } out_t;

    out_t                          out_d, out_q;
    logic [BPP_W-1:0]              bytes_m1;
    chan_sel_t [NUM_CH-1:0]        sel_cfg;
    logic [NUM_CH-1:0][COMP_W-1:0] comp_x;
    logic                          blank;

    assign blank = !in_visible || underrun;

    pix_cfg_regs #(
        .PIX_BYTES (PIX_BYTES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .bytes_m1 (bytes_m1),
        .sel_cfg  (sel_cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pix_comp_extract #(
            .PIX_BYTES (PIX_BYTES)
        ) u_ext (
            .pix_word   (pix_word),
            .bytes_m1   (bytes_m1),
            .sel        (sel_cfg[c]),
            .force_dflt (blank),
            .comp_out   (comp_x[c])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = pix_valid;
        if (pix_valid) begin
            out_d.comp = comp_x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign comp_r    = out_q.comp[0];
    assign comp_g    = out_q.comp[1];
    assign comp_b    = out_q.comp[2];
    assign out_valid = out_q.valid;
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
    import pix_unpack_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pix_valid,
    input logic                   in_visible,
    input logic                   underrun,
    input logic [COMP_W-1:0]      comp_r,
    input logic [COMP_W-1:0]      comp_g,
    input logic [COMP_W-1:0]      comp_b,
    input logic                   out_valid,
    input chan_sel_t [NUM_CH-1:0] sel_cfg
);
    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(pix_valid)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> $stable({comp_r, comp_g, comp_b})); // R9

    AST_BLANK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && (!in_visible || underrun) |=>
            comp_r == $past(sel_cfg[0].dflt) && comp_g == $past(sel_cfg[1].dflt)
            && comp_b == $past(sel_cfg[2].dflt)); // R8

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && sel_cfg[1].len == '0 |=> comp_g == $past(sel_cfg[1].dflt)); // R7
endmodule

bind pix_unpack pix_unpack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .in_visible (in_visible),
    .underrun   (underrun),
    .comp_r     (comp_r),
    .comp_g     (comp_g),
    .comp_b     (comp_b),
    .out_valid  (out_valid),
    .sel_cfg    (sel_cfg)
);

// File: tb/sim_pix_unpack.sv
module sim_pix_unpack;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {bytes_m1[1:0], len[3:0], idx[4:0], word[31:0], expected red[7:0]}
    localparam logic [50:0] VEC [NVEC] = '{
        {2'd3, 4'd8,  5'd16, 32'h12AB3456, 8'hAB},  // R3
        {2'd3, 4'd8,  5'd0,  32'h000000C3, 8'hC3},  // R3
        {2'd3, 4'd5,  5'd11, 32'h0000B000, 8'hB5},  // R4
        {2'd3, 4'd6,  5'd5,  32'h000007E0, 8'hFF},  // R4
        {2'd3, 4'd1,  5'd31, 32'h80000000, 8'hFF},  // R4
        {2'd2, 4'd1,  5'd31, 32'h80000000, 8'h00},  // R6
        {2'd0, 4'd8,  5'd8,  32'h0000FF77, 8'h00},  // R6
        {2'd3, 4'd12, 5'd4,  32'h0000ABC0, 8'hAB},  // R5
        {2'd3, 4'd0,  5'd0,  32'hFFFFFFFF, 8'h5A},  // R7
        {2'd3, 4'd3,  5'd0,  32'h00000005, 8'hB6},  // R4
        {2'd3, 4'd2,  5'd30, 32'h40000000, 8'h55},  // R4
        {2'd3, 4'd4,  5'd28, 32'h90000000, 8'h99}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] pix_word = '0;
    logic        pix_valid = 1'b0;
    logic        in_visible = 1'b0;
    logic        underrun = 1'b0;
    logic [7:0]  comp_r, comp_g, comp_b;
    logic        out_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_unpack u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .pix_word   (pix_word),
        .pix_valid  (pix_valid),
        .in_visible (in_visible),
        .underrun   (underrun),
        .comp_r     (comp_r),
        .comp_g     (comp_g),
        .comp_b     (comp_b),
        .out_valid  (out_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sel_word(input logic [7:0] dflt, input logic [3:0] len,
                                              input logic [4:0] idx);
        return {8'h00, dflt, 4'h0, len, 3'b000, idx};
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // presents one pixel; returns at the negedge after the output register loads
    task automatic send_pix(input logic [31:0] w, input logic vis, input logic und);
        @(negedge clk);
        pix_word = w; pix_valid = 1'b1; in_visible = vis; underrun = und;
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid reset", {31'd0, out_valid}, 32'd0);
        check("R1 comps reset", {8'd0, comp_r, comp_g, comp_b}, 32'd0);
        rst_n = 1'b1;

        send_pix(32'hFFFFFFFF, 1'b1, 1'b0);
        check("R1 config reset gives zero", {8'd0, comp_r, comp_g, comp_b}, 32'd0);
        check("R2 valid follows", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R2 valid drops", {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            reg_write(2'd0, {27'd0, VEC[i][50:49], 3'b000});
            reg_write(2'd1, sel_word(8'h5A, VEC[i][48:45], VEC[i][44:40]));
            send_pix(VEC[i][39:8], 1'b1, 1'b0);
            check($sformatf("R3-table entry %0d red", i), {24'd0, comp_r}, {24'd0, VEC[i][7:0]});
        end

        // R10 address map: three channels on distinct bytes
        reg_write(2'd0, 32'h0000_0018);
        reg_write(2'd1, sel_word(8'h11, 4'd8, 5'd16));
        reg_write(2'd2, sel_word(8'h22, 4'd8, 5'd8));
        reg_write(2'd3, sel_word(8'h33, 4'd8, 5'd0));
        send_pix(32'h00AABBCC, 1'b1, 1'b0);
        check("R10 channel map", {8'd0, comp_r, comp_g, comp_b}, 32'h00AABBCC);

        // R8 blanking and underrun
        send_pix(32'h00AABBCC, 1'b0, 1'b0);
        check("R8 outside visible", {8'd0, comp_r, comp_g, comp_b}, 32'h00112233);
        send_pix(32'h00AABBCC, 1'b1, 1'b1);
        check("R8 underrun", {8'd0, comp_r, comp_g, comp_b}, 32'h00112233);

        // R9 hold while idle
        send_pix(32'h00445566, 1'b1, 1'b0);
        @(negedge clk);
        pix_word = 32'h00FFFFFF; in_visible = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 hold while idle", {8'd0, comp_r, comp_g, comp_b}, 32'h00445566);

        // R7 on green, others untouched (R10 isolation)
        reg_write(2'd2, sel_word(8'h77, 4'd0, 5'd8));
        send_pix(32'h00445566, 1'b1, 1'b0);
        check("R7 green zero count", {24'd0, comp_g}, 32'h77);
        check("R10 red unchanged", {24'd0, comp_r}, 32'h44);
        check("R10 blue unchanged", {24'd0, comp_b}, 32'h66);

        // R10 write in same cycle as pixel uses old setting
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = sel_word(8'h00, 4'd8, 5'd0);
        pix_word = 32'h00123456; pix_valid = 1'b1; in_visible = 1'b1; underrun = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; pix_valid = 1'b0;
        check("R10 same-cycle write uses old", {24'd0, comp_r}, 32'h12);
        send_pix(32'h00123456, 1'b1, 1'b0);
        check("R10 new setting applies next", {24'd0, comp_r}, 32'h56);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule